// File: doc/BRIEF.md
# DMA Channel Command State Machine

This block holds the operating state of one DMA channel (transfer side or event side) and moves it in response to command bytes written by software. A write strobe carries an 8-bit command code; the block answers with an 8-bit state code. Both are packed into one 32-bit status word in the fixed field positions that software decodes. It drives a datapath enable and a quiesce (drain) request toward the channel datapath. It takes an idle input, saying that in-flight work has drained, and a pending input, saying that descriptors are waiting. It also takes an error input from the datapath.

Suspend and reset do not finish at once. The datapath enable drops on the cycle after the command, and quiesce is raised. The state field keeps its previous code until the idle input is seen, and only then shows the final state. A channel with work pending reports running rather than enabled. A datapath error stops an active channel, and only a disable or a reset releases it.

Top module: `chan_cmd_fsm`

## Requirements
- R1: After reset, the state code is 0 (disabled), `status_o` is 0, and `chan_en_o`, `quiesce_o` and `active_o` are all 0.
- R2: Command code 1 (enable) moves a disabled (0) or suspended (3) channel to enabled (1) on the next cycle, and `chan_en_o` is then 1.
- R3: An enabled channel moves to running (2) while `pend_i` is 1 and returns to enabled (1) when `pend_i` is 0. `chan_en_o` stays 1 in both states.
- R4: Command code 2 (suspend) on an enabled or running channel lowers `chan_en_o` and raises `quiesce_o` on the next cycle. The state code is held while `idle_i` is 0 and becomes 3 (suspended) on the cycle after `idle_i` is seen at 1. `quiesce_o` then falls.
- R5: Command code 9 (reset) is accepted in any state, including during a suspend drain. It drains in the same way and always ends in state 0 (disabled), never 3.
- R6: `err_i` on an enabled or running channel that is not draining moves it to stopped (4). In stopped, enable and suspend are ignored. Command code 0 (disable) moves it to disabled at once, and reset moves it to disabled through a drain.
- R7: Command codes other than 0, 1, 2 and 9, such as 5 and 255, are ignored and leave the state unchanged. So is suspend on a disabled channel.
- R8: `status_o` bits 23:16 hold the last accepted command code and bits 15:8 hold the state code. All other bits are 0.
- R9: `active_o` is 1 exactly when the state code is 1 or 2, including while a suspend or reset is draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command code written |
| pend_i | input | 1 | Descriptors are pending |
| idle_i | input | 1 | No transfer is in flight |
| err_i | input | 1 | Datapath error |
| status_o | output | 32 | Packed status word (command and state fields) |
| state_o | output | 8 | Current state code |
| chan_en_o | output | 1 | Datapath enable |
| quiesce_o | output | 1 | Drain request while a suspend or reset is in progress |
| active_o | output | 1 | State code is enabled or running |

## Verification
The bench builds the block with its default parameters: an 8-bit command field at bit 16, an 8-bit state field at bit 8 and a 32-bit status word. These are the values at which the packed field positions of R8 can be checked bit for bit. Each state code is reached from several others, and drains are held open by keeping the idle input low for several cycles. A reset is issued in the middle of a suspend drain, so the case where a drain must end disabled rather than suspended is covered.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

  typedef enum logic [2:0] {
    ST_DIS  = 3'd0,
    ST_EN   = 3'd1,
    ST_RUN  = 3'd2,
    ST_SUSP = 3'd3,
    ST_STOP = 3'd4
  } chan_state_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_DIS,
    K_EN,
    K_SUSP,
    K_RST
  } cmd_kind_e;

  localparam int unsigned CODE_DIS  = 0;
  localparam int unsigned CODE_EN   = 1;
  localparam int unsigned CODE_SUSP = 2;
  localparam int unsigned CODE_RST  = 9;

  function automatic logic is_active(chan_state_e s);
    return (s == ST_EN) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_cmd_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_kind_e        kind_o
);

  always_comb begin
    if (cmd_i == CMD_W'(CODE_DIS))       kind_o = K_DIS;
    else if (cmd_i == CMD_W'(CODE_EN))   kind_o = K_EN;
    else if (cmd_i == CMD_W'(CODE_SUSP)) kind_o = K_SUSP;
    else if (cmd_i == CMD_W'(CODE_RST))  kind_o = K_RST;
    else                                 kind_o = K_NONE;
  end

endmodule

// File: rtl/chan_state_core.sv
module chan_state_core
  import chan_cmd_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  cmd_kind_e        kind_i,
  input  logic             pend_i,
  input  logic             idle_i,
  input  logic             err_i,
  output chan_state_e      state_o,
  output logic [CMD_W-1:0] last_cmd_o,
  output logic             draining_o
);

  chan_state_e      st_q, st_d;
  logic             drain_q, drain_d;
  logic             drst_q, drst_d;
  logic [CMD_W-1:0] lcmd_q, lcmd_d;
  logic             acc;

  always_comb begin
    st_d    = st_q;
    drain_d = drain_q;
    drst_d  = drst_q;
    acc     = 1'b0;
    if (drain_q) begin
      // reset may take over a suspend drain; it restarts the wait
      if (cmd_wr_i && kind_i == K_RST && !drst_q) begin
        drst_d = 1'b1;
        acc    = 1'b1;
      end else if (idle_i) begin
        st_d    = drst_q ? ST_DIS : ST_SUSP;
        drain_d = 1'b0;
        drst_d  = 1'b0;
      end
    end else if (err_i && is_active(st_q)) begin
      st_d = ST_STOP;
    end else begin
      if (st_q == ST_EN && pend_i)   st_d = ST_RUN;
      if (st_q == ST_RUN && !pend_i) st_d = ST_EN;
      if (cmd_wr_i) begin
        unique case (kind_i)
          K_RST: begin
            drain_d = 1'b1;
            drst_d  = 1'b1;
            acc     = 1'b1;
          end
          K_DIS: begin
            st_d = ST_DIS;
            acc  = 1'b1;
          end
          K_EN: begin
            if (st_q == ST_DIS || st_q == ST_SUSP) begin
              st_d = ST_EN;
              acc  = 1'b1;
            end
          end
          K_SUSP: begin
            if (is_active(st_q)) begin
              drain_d = 1'b1;
              acc     = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
    lcmd_d = acc ? cmd_i : lcmd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_DIS;
      drain_q <= 1'b0;
      drst_q  <= 1'b0;
      lcmd_q  <= '0;
    end else begin
      st_q    <= st_d;
      drain_q <= drain_d;
      drst_q  <= drst_d;
      lcmd_q  <= lcmd_d;
    end
  end

  assign state_o    = st_q;
  assign last_cmd_o = lcmd_q;
  assign draining_o = drain_q;

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_q && !idle_i) |=> $stable(st_q)); // R4

  AST_DRAIN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_q) |-> $past(cmd_wr_i)); // R4

  AST_RST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_q && drst_q && idle_i) |=> (st_q == ST_DIS && !drain_q)); // R5

  AST_ERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drain_q && err_i && is_active(st_q)) |=> (st_q == ST_STOP)); // R6

  AST_STOP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q == ST_STOP && !drain_q) && st_q != ST_STOP)
      |-> $past(cmd_wr_i && kind_i == K_DIS)); // R6

endmodule

// File: rtl/chan_status_pack.sv
module chan_status_pack
  import chan_cmd_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned STATE_W   = 8,
  parameter int unsigned CMD_LSB   = 16,
  parameter int unsigned STATE_LSB = 8,
  parameter int unsigned REG_W     = 32
) (
  input  chan_state_e        state_i,
  input  logic [CMD_W-1:0]   cmd_i,
  output logic [STATE_W-1:0] state_o,
  output logic [REG_W-1:0]   word_o
);

  always_comb begin
    state_o = STATE_W'(state_i);
    word_o  = '0;
    word_o[CMD_LSB +: CMD_W]     = cmd_i;
    word_o[STATE_LSB +: STATE_W] = state_o;
  end

endmodule

// File: rtl/chan_cmd_fsm.sv
module chan_cmd_fsm
  import chan_cmd_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned STATE_W   = 8,
  parameter int unsigned CMD_LSB   = 16,
  parameter int unsigned STATE_LSB = 8,
  parameter int unsigned REG_W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               pend_i,
  input  logic               idle_i,
  input  logic               err_i,
  output logic [REG_W-1:0]   status_o,
  output logic [STATE_W-1:0] state_o,
  output logic               chan_en_o,
  output logic               quiesce_o,
  output logic               active_o
);

  cmd_kind_e        kind;
  chan_state_e      st;
  logic [CMD_W-1:0] lcmd;
  logic             draining;

  chan_cmd_decode #(.CMD_W(CMD_W)) i_decode (
    .cmd_i  (cmd_i),
    .kind_o (kind)
  );

  chan_state_core #(.CMD_W(CMD_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .kind_i     (kind),
    .pend_i     (pend_i),
    .idle_i     (idle_i),
    .err_i      (err_i),
    .state_o    (st),
    .last_cmd_o (lcmd),
    .draining_o (draining)
  );

  chan_status_pack #(
    .CMD_W(CMD_W), .STATE_W(STATE_W), .CMD_LSB(CMD_LSB),
    .STATE_LSB(STATE_LSB), .REG_W(REG_W)
  ) i_pack (
    .state_i (st),
    .cmd_i   (lcmd),
    .state_o (state_o),
    .word_o  (status_o)
  );

  assign active_o  = is_active(st);
  assign chan_en_o = active_o && !draining;
  assign quiesce_o = draining;

  AST_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i == CMD_W'(CODE_SUSP) && chan_en_o && !err_i) |=> !chan_en_o); // R4

  AST_FIELD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STATE_LSB +: STATE_W] == state_o); // R8

endmodule

// File: tb/test_chan_cmd_fsm.sv
module test_chan_cmd_fsm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  cmd = '0;
  logic        pend = 1'b0, idle = 1'b0, err = 1'b0;
  logic [31:0] status;
  logic [7:0]  state;
  logic        en, q, act;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chan_cmd_fsm i_chan_cmd_fsm (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(wr), .cmd_i(cmd),
    .pend_i(pend), .idle_i(idle), .err_i(err),
    .status_o(status), .state_o(state), .chan_en_o(en),
    .quiesce_o(q), .active_o(act)
  );

  // {wr, cmd, pend, idle, err, exp_state, exp_en, exp_quiesce}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b0, 8'd0,   1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 1'b0},
    {1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b1, 8'd5,   1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b1, 8'd2,   1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1},
    {1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1},
    {1'b0, 8'd0,   1'b0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0},
    {1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 8'd4, 1'b0, 1'b0},
    {1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 1'b0},
    {1'b1, 8'd2,   1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 1'b0},
    {1'b1, 8'd9,   1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 1'b1},
    {1'b0, 8'd0,   1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0},
    {1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 8'd4, 1'b0, 1'b0},
    {1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0},
    {1'b1, 8'd2,   1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0},
    {1'b1, 8'd1,   1'b1, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0},
    {1'b0, 8'd0,   1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 1'b0},
    {1'b1, 8'd9,   1'b1, 1'b1, 1'b0, 8'd2, 1'b0, 1'b1},
    {1'b0, 8'd0,   1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0},
    {1'b1, 8'd255, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0}
  };

  function automatic string tag(int i);
    case (i)
      0, 7, 13, 17: return "R2";
      1, 2, 18:     return "R3";
      4, 5, 6:      return "R4";
      11, 12, 19, 20: return "R5";
      8, 9, 10, 14, 15: return "R6";
      default:      return "R7";
    endcase
  endfunction

  task automatic chk(string r, string what, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", r, what, act_v, exp_v);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the following negedge
  task automatic step(logic w, logic [7:0] c, logic p, logic i, logic e);
    wr = w; cmd = c; pend = p; idle = i; err = e;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "state", {24'h0, state}, 32'h0);
    chk("R1", "status", status, 32'h0);
    chk("R1", "en/q/act", {29'h0, en, q, act}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][21], VEC[k][20:13], VEC[k][12], VEC[k][11], VEC[k][10]);
      chk(tag(k), $sformatf("row %0d state", k), {24'h0, state}, {24'h0, VEC[k][9:2]});
      chk(tag(k), $sformatf("row %0d en", k), {31'h0, en}, {31'h0, VEC[k][1]});
      chk(tag(k), $sformatf("row %0d quiesce", k), {31'h0, q}, {31'h0, VEC[k][0]});
    end
    chk("R8", "status after reset cmd", status, 32'h0009_0000);

    // R5: reset takes over a suspend drain and ends disabled
    step(1'b1, 8'd1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'd2, 1'b0, 1'b0, 1'b0);
    chk("R9", "active while draining", {31'h0, act}, 32'h1);
    chk("R4", "en while draining", {31'h0, en}, 32'h0);
    step(1'b1, 8'd9, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
    chk("R5", "held during drain", {24'h0, state}, 32'h1);
    step(1'b0, 8'd0, 1'b0, 1'b1, 1'b0);
    chk("R5", "drain end state", {24'h0, state}, 32'h0);
    chk("R9", "inactive when disabled", {31'h0, act}, 32'h0);

    // R8: field positions
    step(1'b1, 8'd1, 1'b0, 1'b0, 1'b0);
    chk("R8", "status enabled", status, 32'h0001_0100);
    step(1'b0, 8'd0, 1'b1, 1'b0, 1'b0);
    chk("R8", "status running", status, 32'h0001_0200);
    chk("R9", "active running", {31'h0, act}, 32'h1);
    step(1'b1, 8'd3, 1'b1, 1'b0, 1'b0);
    chk("R7", "code 3 ignored", status, 32'h0001_0200);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "async status", status, 32'h0);
    chk("R1", "async en", {31'h0, en}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule